// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block pairs a small operation decoder with a 32-bit combinational arithmetic/logic unit. The decoder turns a 2-bit instruction class from the main controller and a 6-bit function field into a 4-bit operation code. Memory and branch classes force a fixed operation whatever the function field holds. Only the register-to-register class looks at the function field.

The ALU side takes two operands and a 4-bit operation code. It returns a result and a flag that is high when the result is zero. The code the decoder produces comes out on its own port, and the ALU's code is a separate input. The integrating datapath normally ties the two together, but it may also drive the ALU directly, for example with the NOR code, which the decoder never produces. There is no clock and no stored state: every output follows its inputs in the same cycle.

Top module: `op_alu`

## Requirements
- R1: With class 00 the decoder outputs code 0010 (add) for every function field value.
- R2: With class 01 the decoder outputs code 0110 (subtract) for every function field value.
- R3: With class 10, function 100000 gives 0010, 100010 gives 0110, 100100 gives 0000, 100101 gives 0001 and 101010 gives 0111.
- R4: With class 11, or with class 10 and any function value not listed in R3, the decoder outputs 0010.
- R5: ALU code 0000 gives the bitwise AND of the operands, 0001 the bitwise OR and 1100 the bitwise NOR.
- R6: ALU code 0010 gives the sum of the operands modulo 2^32, with no overflow indication.
- R7: ALU code 0110 gives operand A minus operand B modulo 2^32.
- R8: ALU code 0111 gives 1 when A is less than B as signed two's-complement values and 0 otherwise, in bit 0, with bits 31:1 zero.
- R9: Any ALU code other than the six in R5 to R8 gives a result of zero.
- R10: The zero flag is high exactly when all 32 result bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Instruction class from the main controller |
| funct | input | 6 | Function field of the instruction |
| ctrl_code | output | 4 | Decoded operation code |
| alu_code | input | 4 | Operation code applied to the ALU |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |

## Verification
The block has no state, so a fault shows at the ports as soon as the inputs settle. A wrong decode entry appears on ctrl_code for one class and function pair only, so every listed function value, every class, and a spread of unlisted function values are driven. Errors in the arithmetic path tend to hide until the carry chain or the sign bits are involved: a wrong carry-in or a wrong overflow term in the signed compare only appears with wrap-around sums and operands whose signs differ. These cases are driven directly, and random operands cover the rest.

// File: rtl/op_alu_pkg.sv
package op_alu_pkg;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_code_e;

  typedef enum logic [1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_RTYPE  = 2'b10,
    CLS_SPARE  = 2'b11
  } op_class_e;

  localparam int FUNCT_W = 6;
  localparam int CODE_W  = 4;
  localparam int CLASS_W = 2;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2
  } logic_sel_e;

endpackage

// File: rtl/op_alu_decode.sv
module op_alu_decode
  import op_alu_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class,
  input  logic [FUNCT_W-1:0] funct,
  output logic [CODE_W-1:0]  ctrl_code
);

  logic [CODE_W-1:0] rtype_code;

  // second level: only consulted for register-to-register class
  always_comb begin
    case (funct)
      FN_ADD:  rtype_code = ALU_ADD;
      FN_SUB:  rtype_code = ALU_SUB;
      FN_AND:  rtype_code = ALU_AND;
      FN_OR:   rtype_code = ALU_OR;
      FN_SLT:  rtype_code = ALU_SLT;
      default: rtype_code = ALU_ADD;
    endcase
  end

  // first level: class overrides the function field
  always_comb begin
    case (op_class)
      CLS_MEM:    ctrl_code = ALU_ADD;
      CLS_BRANCH: ctrl_code = ALU_SUB;
      CLS_RTYPE:  ctrl_code = rtype_code;
      default:    ctrl_code = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/op_alu_logic.sv
module op_alu_logic
  import op_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] y
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      case (sel)
        LG_OR:   y[i] = a[i] | b[i];
        LG_NOR:  y[i] = ~(a[i] | b[i]);
        default: y[i] = a[i] & b[i];
      endcase
    end
  end

endmodule

// File: rtl/op_alu_arith.sv
module op_alu_arith #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             less
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] cin_vec;

  assign b_eff   = subtract ? ~b : b;
  assign cin_vec = {{(WIDTH-1){1'b0}}, subtract};
  assign sum     = a + b_eff + cin_vec;

  // signed compare from the difference; operands of differing sign
  // decide by sign of A alone, avoiding the overflowed difference
  assign less = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];

endmodule

// File: rtl/op_alu.sv
module op_alu
  import op_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_class,
  input  logic [5:0]       funct,
  output logic [3:0]       ctrl_code,
  input  logic [3:0]       alu_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] arith_sum;
  logic             arith_less;
  logic             do_sub;
  logic [1:0]       lsel;

  op_alu_decode u_dec (
    .op_class (op_class),
    .funct    (funct),
    .ctrl_code(ctrl_code)
  );

  always_comb begin
    case (alu_code)
      ALU_OR:  lsel = LG_OR;
      ALU_NOR: lsel = LG_NOR;
      default: lsel = LG_AND;
    endcase
  end

  assign do_sub = (alu_code == ALU_SUB) || (alu_code == ALU_SLT);

  op_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a  (opnd_a),
    .b  (opnd_b),
    .sel(lsel),
    .y  (logic_y)
  );

  op_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a       (opnd_a),
    .b       (opnd_b),
    .subtract(do_sub),
    .sum     (arith_sum),
    .less    (arith_less)
  );

  always_comb begin
    case (alu_code)
      ALU_AND, ALU_OR, ALU_NOR: result = logic_y;
      ALU_ADD, ALU_SUB:         result = arith_sum;
      ALU_SLT:                  result = {{(WIDTH-1){1'b0}}, arith_less};
      default:                  result = '0;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/op_alu_chk.sv
module op_alu_chk
  import op_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [1:0]       op_class,
  input logic [5:0]       funct,
  input logic [3:0]       ctrl_code,
  input logic [3:0]       alu_code,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result,
  input logic             zero
);

  always_comb begin
    // R1
    if (op_class == CLS_MEM)
      mem_class_add_chk: assert (ctrl_code == ALU_ADD);
    // R2
    if (op_class == CLS_BRANCH)
      branch_class_sub_chk: assert (ctrl_code == ALU_SUB);
    // R4
    if (op_class == CLS_SPARE)
      spare_class_add_chk: assert (ctrl_code == ALU_ADD);
    // R5
    if (alu_code == ALU_NOR)
      nor_result_chk: assert (result == ~(opnd_a | opnd_b));
    // R8
    if (alu_code == ALU_SLT)
      slt_upper_zero_chk: assert (result[WIDTH-1:1] == '0);
    // R9
    if (!(alu_code inside {ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT, ALU_NOR}))
      unused_code_zero_chk: assert (result == '0);
    // R10
    zero_flag_chk: assert (zero == (result == '0));
    if (funct == 6'b0) begin end
  end

endmodule

bind op_alu op_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op_class (op_class),
  .funct    (funct),
  .ctrl_code(ctrl_code),
  .alu_code (alu_code),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .result   (result),
  .zero     (zero)
);

// File: tb/op_alu_test.sv
module op_alu_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [1:0]   op_class;
  logic [5:0]   funct;
  logic [3:0]   ctrl_code;
  logic [3:0]   alu_code;
  logic [W-1:0] opnd_a, opnd_b, result;
  logic         zero;

  int checks = 0;
  int errors = 0;

  op_alu #(.WIDTH(W)) uut (
    .op_class (op_class),
    .funct    (funct),
    .ctrl_code(ctrl_code),
    .alu_code (alu_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .zero     (zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] exp_code(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 4'b0010;
    if (c == 2'b01) return 4'b0110;
    if (c == 2'b10) begin
      if (f == 6'b100000) return 4'b0010;
      if (f == 6'b100010) return 4'b0110;
      if (f == 6'b100100) return 4'b0000;
      if (f == 6'b100101) return 4'b0001;
      if (f == 6'b101010) return 4'b0111;
    end
    return 4'b0010;
  endfunction

  function automatic logic [W-1:0] exp_res(input logic [3:0] k, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (k)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b1100: return ~(a | b);
      4'b0010: return a + b;
      4'b0110: return a - b;
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_dec(input string tag, input logic [1:0] c, input logic [5:0] f);
    op_class = c; funct = f;
    #(CLK_PERIOD);
    check(tag, {28'd0, ctrl_code}, {28'd0, exp_code(c, f)});
  endtask

  task automatic run_alu(input string tag, input logic [3:0] k, input logic [W-1:0] a,
                         input logic [W-1:0] b);
    logic [W-1:0] e;
    alu_code = k; opnd_a = a; opnd_b = b;
    #(CLK_PERIOD);
    e = exp_res(k, a, b);
    check(tag, result, e);
    check("R10 zero flag", {31'd0, zero}, {31'd0, (e == '0)});
  endtask

  function automatic string tag_for(input logic [3:0] k);
    case (k)
      4'b0000, 4'b0001, 4'b1100: return "R5 logic";
      4'b0010: return "R6 add";
      4'b0110: return "R7 sub";
      4'b0111: return "R8 slt";
      default: return "R9 unused code";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] codes [6];
    codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    void'($urandom(32'd20240611));
    op_class = 2'b00; funct = '0; alu_code = 4'b0000; opnd_a = '0; opnd_b = '0;
    #(CLK_PERIOD/2);
    // initial state: class 00, AND of zeros
    run_dec("R1 initial", 2'b00, 6'b0);
    run_alu("R5 initial", 4'b0000, '0, '0);

    // directed decode: every listed funct under each class
    for (int c = 0; c < 4; c++) begin
      run_dec("R3 add fn", c[1:0], 6'b100000);
      run_dec("R3 sub fn", c[1:0], 6'b100010);
      run_dec("R3 and fn", c[1:0], 6'b100100);
      run_dec("R3 or fn",  c[1:0], 6'b100101);
      run_dec("R3 slt fn", c[1:0], 6'b101010);
      run_dec("R4 unlisted fn", c[1:0], 6'b100111);
    end
    // random decode by class
    for (int i = 0; i < 64; i++) begin
      logic [5:0] f = 6'($urandom);
      run_dec("R1 mem class",    2'b00, f);
      run_dec("R2 branch class", 2'b01, f);
      run_dec("R3 rtype class",  2'b10, f);
      run_dec("R4 spare class",  2'b11, f);
    end

    // directed ALU corners
    run_alu("R6 wrap to zero",  4'b0010, 32'hFFFF_FFFF, 32'h1);
    run_alu("R6 carry chain",   4'b0010, 32'h7FFF_FFFF, 32'h1);
    run_alu("R7 borrow wrap",   4'b0110, 32'h0, 32'h1);
    run_alu("R7 equal to zero", 4'b0110, 32'h1234_5678, 32'h1234_5678);
    run_alu("R8 min lt one",    4'b0111, 32'h8000_0000, 32'h1);
    run_alu("R8 one lt min",    4'b0111, 32'h1, 32'h8000_0000);
    run_alu("R8 max vs min",    4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
    run_alu("R8 neg lt pos",    4'b0111, 32'hFFFF_FFFF, 32'h0);
    run_alu("R8 equal",         4'b0111, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    run_alu("R8 small lt",      4'b0111, 32'd3, 32'd4);
    run_alu("R5 nor zeros",     4'b1100, 32'h0, 32'h0);
    run_alu("R5 nor ones",      4'b1100, 32'hFFFF_FFFF, 32'h0);
    run_alu("R5 and disjoint",  4'b0000, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    run_alu("R5 or disjoint",   4'b0001, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    for (int k = 0; k < 16; k++)
      run_alu(tag_for(k[3:0]), k[3:0], 32'hA5A5_0F0F, 32'h5A5A_F0F1);

    // random operands, listed codes
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a = $urandom;
      logic [W-1:0] b = $urandom;
      logic [3:0]   k = codes[$urandom % 6];
      if (($urandom % 8) == 0) b = a;
      if (($urandom % 8) == 0) a[W-1] = ~b[W-1];
      run_alu(tag_for(k), k, a, b);
    end

    // decoder driving the ALU end to end
    for (int i = 0; i < 40; i++) begin
      logic [5:0] f = (i % 2 == 0) ? 6'b101010 : 6'b100010;
      op_class = 2'b10; funct = f;
      #1;
      run_alu(tag_for(ctrl_code), ctrl_code, $urandom, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule